// File: doc/BRIEF.md
# Instruction Cycle Timing Sequencer

This block is the timing core of a 16-bit accumulator processor. A sequence counter steps through the timing slots T0 to T6 and shows each slot as one bit of a one-hot pulse vector. The block runs three front-end phases itself. In T0 it copies the program counter into the address register. In T1 it loads the instruction register from memory and increments the program counter. In T2 it decodes the instruction. When the instruction uses indirect addressing, it also replaces the address register with a memory word during T3.

After decode, the three-bit operation field appears as eight one-hot lines, and the top word bit is held as an addressing-mode flag. The execute units take the pulses, the decoded lines, the mode flag and the register values from the block's outputs. When an instruction is finished, they return the sequence to T0 with a clear request. They can also stop the machine with a halt request, which drops the run flag. Memory has a single address port. Read data is expected in the same cycle as the address that the block presents.

Top module: `instr_cycle_seq`

## Requirements
- R1: A synchronous reset makes the counter zero, the program counter zero and the instruction register zero, and sets the run flag. After reset, `tPulse` is 7'b0000001 and `running` is 1.
- R2: While running, at most one bit of `tPulse` is set, and bit k stands for slot Tk. With no clear, the slot advances by one each cycle. Counter values from 7 to 15 raise no pulse.
- R3: The edge at the end of T0 loads the address register with the program counter. `memAddr` always equals `arOut`.
- R4: During T1 `memRead` is 1. The edge at the end of T1 loads the instruction register with `memRdata` and increments the 12-bit program counter.
- R5: The edge at the end of T2 does three things. It sets bit n of `opDec`, where n is instruction bits 14..12, with all other bits clear. It copies instruction bit 15 into `indirect`. It loads the address register with instruction bits 11..0.
- R6: In T3, when `opDec[7]` is 0 and `indirect` is 1, `memRead` is 1. The next edge loads the address register with bits 11..0 of `memRdata`.
- R7: In T3, when `opDec[7]` is 0 and `indirect` is 0, the block does no memory read and leaves the address register unchanged. It then goes on to T4.
- R8: In T3, when `opDec[7]` is 1, the block does no memory read and leaves the address register unchanged, whatever the mode flag holds.
- R9: A `scClr` request in any slot sets the counter to zero at the next edge, so the next slot is T0. The clear takes precedence over the increment.
- R10: `haltReq` clears the run flag, and only a reset sets it again. While the flag is clear: `tPulse` is all zero, and the counter, program counter, address register and instruction register hold their values even if memory data changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scClr | input | 1 | Clear request from the execute units: the next slot is T0 |
| haltReq | input | 1 | Halt request: clears the run flag |
| memRdata | input | 16 | Memory read data for the address on memAddr |
| memAddr | output | 12 | Memory address (the address register) |
| memRead | output | 1 | Memory read strobe (T1, and indirect T3) |
| tPulse | output | 7 | One-hot timing pulses T0..T6 |
| opDec | output | 8 | Decoded operation lines D0..D7 |
| indirect | output | 1 | Latched addressing-mode bit |
| running | output | 1 | Run flag |
| pcOut | output | 12 | Program counter |
| arOut | output | 12 | Address register |
| irOut | output | 16 | Instruction register |

## Verification
The bench sends instruction words that take each of the four T3 paths: direct memory, indirect memory, register type and I/O type. The memory words placed at the target addresses differ from the decoded addresses, so an indirect load that was wrongly taken or wrongly skipped shows up in the address register. A direct instruction left without a clear shows the slot walking to T6 and then going dark. An early clear in T1 shows that the clear wins over the increment while the T1 load still completes. A halt combined with a clear, followed by changes to memory, shows that nothing moves while the run flag is low, and a second reset shows that the flag comes back.

// File: rtl/iseq_pkg.sv
package iseq_pkg;
  // Strobes from the control to the datapath, one per front-end action.
  typedef struct packed {
    logic arFromPc;
    logic fetchIr;
    logic decode;
    logic arFromMem;
  } seqStrobes_t;
endpackage

// File: rtl/iseq_ctrl.sv
module iseq_ctrl
  import iseq_pkg::*;
#(
  parameter int SC_W  = 4,
  parameter int NUM_T = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scClr,
  input  logic              haltReq,
  input  logic              isRegIo,
  input  logic              indirect,
  output seqStrobes_t       strobes,
  output logic [NUM_T-1:0]  tPulse,
  output logic              running,
  output logic              memRead
);
  logic [SC_W-1:0] sc;
  logic            runFlag;

  always_ff @(posedge clk) begin
    if (rst) begin
      sc      <= '0;
      runFlag <= 1'b1;
    end else begin
      if (haltReq) runFlag <= 1'b0;
      if (scClr)        sc <= '0;
      else if (runFlag) sc <= sc + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_T; k++) begin : g_pulse
    assign tPulse[k] = runFlag && (sc == SC_W'(k));
  end

  always_comb begin
    strobes.arFromPc  = tPulse[0];
    strobes.fetchIr   = tPulse[1];
    strobes.decode    = tPulse[2];
    strobes.arFromMem = tPulse[3] && !isRegIo && indirect;
  end

  assign memRead = strobes.fetchIr | strobes.arFromMem;
  assign running = runFlag;
endmodule

// File: rtl/iseq_datapath.sv
module iseq_datapath
  import iseq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12,
  parameter int OPC_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  seqStrobes_t               strobes,
  input  logic [WORD_W-1:0]         memRdata,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [ADDR_W-1:0]         pcOut,
  output logic [ADDR_W-1:0]         arOut,
  output logic [WORD_W-1:0]         irOut,
  output logic [(1<<OPC_W)-1:0]     opDec,
  output logic                      indirect
);
  localparam int NUM_OPS  = 1 << OPC_W;
  localparam int OPC_LSB  = ADDR_W;
  localparam int MODE_BIT = WORD_W - 1;

  logic [ADDR_W-1:0]  pc, ar;
  logic [WORD_W-1:0]  ir;
  logic [NUM_OPS-1:0] decReg, decNext;
  logic               modeReg;
  logic [OPC_W-1:0]   opField;

  assign opField = ir[OPC_LSB +: OPC_W];

  for (genvar n = 0; n < NUM_OPS; n++) begin : g_dec
    assign decNext[n] = (opField == OPC_W'(n));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      ar      <= '0;
      ir      <= '0;
      decReg  <= '0;
      modeReg <= 1'b0;
    end else begin
      if (strobes.arFromPc)       ar <= pc;
      else if (strobes.decode)    ar <= ir[ADDR_W-1:0];
      else if (strobes.arFromMem) ar <= memRdata[ADDR_W-1:0];
      if (strobes.fetchIr) begin
        ir <= memRdata;
        pc <= pc + 1'b1;
      end
      if (strobes.decode) begin
        decReg  <= decNext;
        modeReg <= ir[MODE_BIT];
      end
    end
  end

  assign memAddr  = ar;
  assign pcOut    = pc;
  assign arOut    = ar;
  assign irOut    = ir;
  assign opDec    = decReg;
  assign indirect = modeReg;
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import iseq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12,
  parameter int OPC_W  = 3,
  parameter int SC_W   = 4,
  parameter int NUM_T  = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scClr,
  input  logic                  haltReq,
  input  logic [WORD_W-1:0]     memRdata,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memRead,
  output logic [NUM_T-1:0]      tPulse,
  output logic [(1<<OPC_W)-1:0] opDec,
  output logic                  indirect,
  output logic                  running,
  output logic [ADDR_W-1:0]     pcOut,
  output logic [ADDR_W-1:0]     arOut,
  output logic [WORD_W-1:0]     irOut
);
  localparam int NUM_OPS = 1 << OPC_W;

  seqStrobes_t strobes;

  iseq_ctrl #(.SC_W(SC_W), .NUM_T(NUM_T)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .scClr    (scClr),
    .haltReq  (haltReq),
    .isRegIo  (opDec[NUM_OPS-1]),
    .indirect (indirect),
    .strobes  (strobes),
    .tPulse   (tPulse),
    .running  (running),
    .memRead  (memRead)
  );

  iseq_datapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .pcOut    (pcOut),
    .arOut    (arOut),
    .irOut    (irOut),
    .opDec    (opDec),
    .indirect (indirect)
  );
endmodule

// File: rtl/iseq_checker.sv
module iseq_checker #(
  parameter int ADDR_W  = 12,
  parameter int NUM_T   = 7,
  parameter int NUM_OPS = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               scClr,
  input logic               haltReq,
  input logic               memRead,
  input logic [ADDR_W-1:0]  memAddr,
  input logic [NUM_T-1:0]   tPulse,
  input logic [NUM_OPS-1:0] opDec,
  input logic               indirect,
  input logic               running,
  input logic [ADDR_W-1:0]  pcOut,
  input logic [ADDR_W-1:0]  arOut
);
  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tPulse)); // R2
  AST_T0_TO_T1: assert property (@(posedge clk) disable iff (rst)
    (tPulse[0] && !scClr && !haltReq) |=> tPulse[1]); // R2
  AST_AR_FROM_PC: assert property (@(posedge clk) disable iff (rst)
    tPulse[0] |=> (arOut == $past(pcOut))); // R3
  AST_ADDR_IS_AR: assert property (@(posedge clk) disable iff (rst)
    memAddr == arOut); // R3
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    tPulse[1] |=> (pcOut == $past(pcOut) + 1'b1)); // R4
  AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    tPulse[3] |-> $onehot(opDec)); // R5
  AST_INDIRECT_READ: assert property (@(posedge clk) disable iff (rst)
    (tPulse[3] && !opDec[NUM_OPS-1] && indirect) |-> memRead); // R6
  AST_T3_AR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tPulse[3] && (opDec[NUM_OPS-1] || !indirect)) |=> $stable(arOut)); // R8
  AST_CLEAR_TO_T0: assert property (@(posedge clk) disable iff (rst)
    (scClr && running && !haltReq) |=> tPulse[0]); // R9
  AST_STOP_DARK: assert property (@(posedge clk) disable iff (rst)
    !running |-> (tPulse == '0)); // R10
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !running |=> ($stable(pcOut) && $stable(arOut) && !running)); // R10
endmodule

bind instr_cycle_seq iseq_checker #(
  .ADDR_W(ADDR_W), .NUM_T(NUM_T), .NUM_OPS(NUM_OPS)
) u_chk (
  .clk(clk), .rst(rst), .scClr(scClr), .haltReq(haltReq),
  .memRead(memRead), .memAddr(memAddr), .tPulse(tPulse), .opDec(opDec),
  .indirect(indirect), .running(running), .pcOut(pcOut), .arOut(arOut)
);

// File: tb/instr_cycle_seq_tb.sv
module instr_cycle_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scClr = 1'b0;
  logic        haltReq = 1'b0;
  logic [15:0] memRdata;
  logic [11:0] memAddr, pcOut, arOut;
  logic        memRead, indirect, running;
  logic [6:0]  tPulse;
  logic [7:0]  opDec;
  logic [15:0] irOut;
  logic [15:0] mem [0:4095];
  int nRun = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  assign memRdata = mem[memAddr];

  instr_cycle_seq u_dut (
    .clk(clk), .rst(rst), .scClr(scClr), .haltReq(haltReq),
    .memRdata(memRdata), .memAddr(memAddr), .memRead(memRead),
    .tPulse(tPulse), .opDec(opDec), .indirect(indirect), .running(running),
    .pcOut(pcOut), .arOut(arOut), .irOut(irOut)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Runs T0..T2 and stops at T3, checking each slot.
  task automatic fetchTo3(input logic [11:0] pcExp, input logic [15:0] word);
    chk("R2", "T0 pulse", tPulse, 7'h01);
    chk("R3", "pc at T0", pcOut, pcExp);
    step();
    chk("R2", "T1 pulse", tPulse, 7'h02);
    chk("R3", "ar after T0", arOut, pcExp);
    chk("R3", "memAddr follows ar", memAddr, pcExp);
    chk("R4", "read in T1", memRead, 1'b1);
    step();
    chk("R2", "T2 pulse", tPulse, 7'h04);
    chk("R4", "ir loaded", irOut, word);
    chk("R4", "pc incremented", pcOut, pcExp + 12'd1);
    step();
    chk("R2", "T3 pulse", tPulse, 7'h08);
    chk("R5", "opDec", opDec, 8'd1 << word[14:12]);
    chk("R5", "mode flag", indirect, word[15]);
    chk("R5", "ar from ir", arOut, word[11:0]);
  endtask

  task automatic clearOnce();
    scClr = 1'b1;
    step();
    scClr = 1'b0;
  endtask

  task automatic testReset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
    chk("R1", "pulse after reset", tPulse, 7'h01);
    chk("R1", "run flag", running, 1'b1);
    chk("R1", "pc zero", pcOut, 12'h000);
    chk("R1", "ir zero", irOut, 16'h0000);
  endtask

  task automatic testDirect();
    fetchTo3(12'h000, 16'h2123);
    chk("R7", "no read in direct T3", memRead, 1'b0);
    step();
    chk("R7", "T4 reached", tPulse, 7'h10);
    chk("R7", "ar kept", arOut, 12'h123);
    step();
    chk("R2", "T5 pulse", tPulse, 7'h20);
    step();
    chk("R2", "T6 pulse", tPulse, 7'h40);
    step();
    chk("R2", "no pulse past T6", tPulse, 7'h00);
    clearOnce();
    chk("R9", "clear from count 7", tPulse, 7'h01);
  endtask

  task automatic testIndirect();
    fetchTo3(12'h001, 16'h9200);
    chk("R6", "read in indirect T3", memRead, 1'b1);
    chk("R6", "memAddr at T3", memAddr, 12'h200);
    step();
    chk("R6", "ar from memory", arOut, 12'hABC);
    chk("R2", "T4 pulse", tPulse, 7'h10);
    clearOnce();
    chk("R9", "clear in T4", tPulse, 7'h01);
  endtask

  task automatic testRegIo(input logic [11:0] pcExp, input logic [15:0] word);
    fetchTo3(pcExp, word);
    chk("R8", "no read for D7", memRead, 1'b0);
    clearOnce();
    chk("R9", "clear in T3", tPulse, 7'h01);
    chk("R8", "ar unchanged for D7", arOut, word[11:0]);
  endtask

  task automatic testEarlyClear();
    chk("R2", "T0 before early clear", tPulse, 7'h01);
    step();
    clearOnce();
    chk("R9", "clear in T1 wins", tPulse, 7'h01);
    chk("R9", "pc still stepped", pcOut, 12'h005);
    chk("R9", "ir still loaded", irOut, 16'h0010);
  endtask

  task automatic testHalt();
    fetchTo3(12'h005, 16'h7001);
    haltReq = 1'b1;
    scClr = 1'b1;
    step();
    haltReq = 1'b0;
    scClr = 1'b0;
    chk("R10", "run flag dropped", running, 1'b0);
    chk("R10", "pulses dark", tPulse, 7'h00);
    mem[12'h001] = 16'h3FFF;
    mem[12'h006] = 16'h1234;
    for (int i = 0; i < 5; i++) step();
    chk("R10", "pc held", pcOut, 12'h006);
    chk("R10", "ar held", arOut, 12'h001);
    chk("R10", "ir held", irOut, 16'h7001);
    chk("R10", "still dark", tPulse, 7'h00);
    chk("R10", "still stopped", running, 1'b0);
  endtask

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] = 16'h0000;
    mem[12'h000] = 16'h2123;
    mem[12'h001] = 16'h9200;
    mem[12'h002] = 16'h7800;
    mem[12'h003] = 16'hF400;
    mem[12'h004] = 16'h0010;
    mem[12'h005] = 16'h7001;
    mem[12'h200] = 16'h0ABC;
    mem[12'h800] = 16'h0555;
    mem[12'h400] = 16'h0666;
    @(negedge clk);
    testReset();
    testDirect();
    testIndirect();
    testRegIo(12'h002, 16'h7800);
    testRegIo(12'h003, 16'hF400);
    testEarlyClear();
    testHalt();
    testReset();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog run did not finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule